// File: doc/BRIEF.md
# MSI Interrupt Capture Controller

This block watches an inbound memory-write request stream for message-signalled interrupts and turns each matching write into a pending bit for one interrupt vector. A write is a message when its 64-bit address equals a target address that software programs. The low data word of such a write is the vector number. The vector's status bit is set only if software has enabled that vector.

Vectors are grouped in banks of 32. Each bank has an enable, a mask and a status register, all reached through a plain 32-bit register port. Status bits are cleared by writing ones to them. A single interrupt output stays high while any status bit is set whose mask bit is clear. The number of banks is a parameter. The default is 8 banks, which gives 256 vectors.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the target address, all enable, mask and status registers, `reg_rdata_o` and `irq_o` are zero.
- R2: The target address low word sits at offset 0x820 and the high word at 0x824. Both read back what was written.
- R3: Bank n has its enable register at 0x828+12n, its mask register at 0x82C+12n and its status register at 0x830+12n. Vector v maps to bank v/32, bit v%32.
- R4: A write with `mw_valid_i` high, an address equal to {high word, low word} and an enabled vector v in the data sets status bit v at the clock edge that takes the write.
- R5: A write whose address differs from the target in any bit sets no status bit.
- R6: A message for a vector whose enable bit is 0 is dropped and sets no status.
- R7: A message whose 32-bit data is at or above 32*NUM_BANKS is ignored. There is no aliasing on the low bits.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A register write never sets a status bit.
- R9: If a capture and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly while some status bit is set with its mask bit 0. Mask bits do not hide status on readback.
- R11: Offsets that are not decoded, including misaligned ones and those past the last bank, read as zero. Writes to them have no effect.
- R12: A read strobe at edge k loads `reg_rdata_o` at edge k with the value the register held before that edge. The value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mw_valid_i | input | 1 | Memory-write request valid |
| mw_addr_i | input | 64 | Memory-write byte address |
| mw_data_i | input | 32 | Memory-write data (vector number) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined pending interrupt |

## Verification
A captured message shows in the status register, and in `irq_o`, right after the edge that takes it. A register write also takes effect at that edge, so `irq_o` is sampled on the falling edge that ends the driving task. Read data is registered one edge after the strobe. A monitor therefore compares each queued expectation on the falling edge that follows the edge recorded as having taken the read. One direct check confirms that `reg_rdata_o` still holds the previous value before that edge.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned VEC_PER_BANK = 32;
  localparam int unsigned BIT_IDX_W    = 5;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned TGT_LO_OFFS  = 'h820;
  localparam int unsigned TGT_HI_OFFS  = 'h824;
  localparam int unsigned BANK0_OFFS   = 'h828;
  localparam int unsigned BANK_STRIDE  = 12;

  typedef enum logic [1:0] {
    BREG_ENABLE = 2'd0,
    BREG_MASK   = 2'd1,
    BREG_STATUS = 2'd2
  } bank_reg_e;

  typedef struct packed {
    logic [REG_W-1:0] enable;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] status;
  } bank_view_t;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 mw_valid_i,
  input  logic [ADDR_W-1:0]    mw_addr_i,
  input  logic [DATA_W-1:0]    mw_data_i,
  input  logic [ADDR_W-1:0]    target_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output logic [BIT_IDX_W-1:0] bit_idx_o
);
  localparam int unsigned NUM_VEC = NUM_BANKS * VEC_PER_BANK;
  localparam int unsigned HI_W    = DATA_W - BIT_IDX_W;

  logic msg_ok;

  // full-word range check: no aliasing of high data bits
  assign msg_ok    = mw_valid_i && (mw_addr_i == target_i)
                  && (mw_data_i < DATA_W'(NUM_VEC));
  assign bit_idx_o = mw_data_i[BIT_IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit_o[b] = msg_ok && (mw_data_i[DATA_W-1:BIT_IDX_W] == HI_W'(b));
  end
endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned OFFS_W    = 12
) (
  input  logic [OFFS_W-1:0]    addr_i,
  output logic                 sel_tgt_lo_o,
  output logic                 sel_tgt_hi_o,
  output logic [NUM_BANKS-1:0] sel_en_o,
  output logic [NUM_BANKS-1:0] sel_mask_o,
  output logic [NUM_BANKS-1:0] sel_stat_o
);
  assign sel_tgt_lo_o = (addr_i == OFFS_W'(TGT_LO_OFFS));
  assign sel_tgt_hi_o = (addr_i == OFFS_W'(TGT_HI_OFFS));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = BANK0_OFFS + BANK_STRIDE * b;
    assign sel_en_o[b]   = (addr_i == OFFS_W'(BASE + 4 * int'(BREG_ENABLE)));
    assign sel_mask_o[b] = (addr_i == OFFS_W'(BASE + 4 * int'(BREG_MASK)));
    assign sel_stat_o[b] = (addr_i == OFFS_W'(BASE + 4 * int'(BREG_STATUS)));
  end
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
  import msi_cap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_mask_i,
  input  logic                 wr_stat_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 cap_i,
  input  logic [BIT_IDX_W-1:0] cap_bit_i,
  output bank_view_t           view_o,
  output logic                 pend_o
);
  logic [REG_W-1:0] enable_q, mask_q, status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (wr_stat_i) status_d = status_d & ~wdata_i;
    // capture after clear: capture wins on a shared bit
    if (cap_i && enable_q[cap_bit_i]) status_d[cap_bit_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_en_i)   enable_q <= wdata_i;
      if (wr_mask_i) mask_q   <= wdata_i;
      status_q <= status_d;
    end
  end

  assign view_o = '{enable: enable_q, mask: mask_q, status: status_q};
  assign pend_o = |(status_q & ~mask_q);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OFFS_W    = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mw_valid_i,
  input  logic [63:0]        mw_addr_i,
  input  logic [31:0]        mw_data_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned NUM_VEC = NUM_BANKS * VEC_PER_BANK;

  logic [REG_W-1:0]     tgt_lo_q, tgt_hi_q;
  logic [ADDR_W-1:0]    tgt_addr;
  logic                 sel_lo, sel_hi;
  logic [NUM_BANKS-1:0] sel_en, sel_mask, sel_stat;
  logic [NUM_BANKS-1:0] bank_hit, bank_pend;
  logic [BIT_IDX_W-1:0] cap_bit;
  bank_view_t           view [NUM_BANKS];
  logic [NUM_VEC-1:0]   status_all, mask_all;
  logic [REG_W-1:0]     rd_mux;
  logic [REG_W-1:0]     rdata_q;

  assign tgt_addr = ADDR_W'({tgt_hi_q, tgt_lo_q});

  msi_reg_decode #(.NUM_BANKS(NUM_BANKS), .OFFS_W(OFFS_W)) u_dec (
    .addr_i       (OFFS_W'(reg_addr_i)),
    .sel_tgt_lo_o (sel_lo),
    .sel_tgt_hi_o (sel_hi),
    .sel_en_o     (sel_en),
    .sel_mask_o   (sel_mask),
    .sel_stat_o   (sel_stat)
  );

  msi_addr_match #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .mw_valid_i (mw_valid_i),
    .mw_addr_i  (ADDR_W'(mw_addr_i)),
    .mw_data_i  (DATA_W'(mw_data_i)),
    .target_i   (tgt_addr),
    .bank_hit_o (bank_hit),
    .bit_idx_o  (cap_bit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msi_vec_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (reg_we_i && sel_en[b]),
      .wr_mask_i (reg_we_i && sel_mask[b]),
      .wr_stat_i (reg_we_i && sel_stat[b]),
      .wdata_i   (reg_wdata_i),
      .cap_i     (bank_hit[b]),
      .cap_bit_i (cap_bit),
      .view_o    (view[b]),
      .pend_o    (bank_pend[b])
    );
    assign status_all[b*VEC_PER_BANK +: VEC_PER_BANK] = view[b].status;
    assign mask_all[b*VEC_PER_BANK +: VEC_PER_BANK]   = view[b].mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (reg_we_i) begin
      if (sel_lo) tgt_lo_q <= reg_wdata_i;
      if (sel_hi) tgt_hi_q <= reg_wdata_i;
    end
  end

  // selects are mutually exclusive; OR-combine keeps the mux shallow
  always_comb begin
    rd_mux = '0;
    if (sel_lo) rd_mux = rd_mux | tgt_lo_q;
    if (sel_hi) rd_mux = rd_mux | tgt_hi_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_en[b])   rd_mux = rd_mux | view[b].enable;
      if (sel_mask[b]) rd_mux = rd_mux | view[b].mask;
      if (sel_stat[b]) rd_mux = rd_mux | view[b].status;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |bank_pend;
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      mw_valid_i,
  input logic [63:0]               mw_addr_i,
  input logic                      reg_we_i,
  input logic                      irq_o,
  input logic [63:0]               tgt_addr,
  input logic [NUM_BANKS*32-1:0]   status_all,
  input logic [NUM_BANKS*32-1:0]   mask_all
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (status_all == '0 && mask_all == '0 && !irq_o)
        else $error("reset state not clear");
    end
  end

  // R4
  one_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_all & ~$past(status_all)) <= 1)
    else $error("more than one status bit rose");

  // R4
  rise_needs_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_all & ~$past(status_all)) != '0) |-> $past(mw_valid_i))
    else $error("status rose without a message");

  // R5
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_valid_i && (mw_addr_i != tgt_addr)) |=> ((status_all & ~$past(status_all)) == '0))
    else $error("status set by mismatched address");

  // R8
  fall_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~status_all & $past(status_all)) != '0) |-> $past(reg_we_i))
    else $error("status cleared without register write");

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (!$stable(status_all) || !$stable(mask_all)))
    else $error("irq rose with no state change");
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mw_valid_i (mw_valid_i),
  .mw_addr_i  (mw_addr_i),
  .reg_we_i   (reg_we_i),
  .irq_o      (irq_o),
  .tgt_addr   (64'(tgt_addr)),
  .status_all (status_all),
  .mask_all   (mask_all)
);

// File: tb/msi_capture_ctrl_tb_top.sv
module msi_capture_ctrl_tb_top;
  localparam logic [31:0] TGT_LO = 32'hFEE0_1000;
  localparam logic [63:0] TGT    = {32'h0, TGT_LO};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mw_valid = 1'b0;
  logic [63:0] mw_addr = '0;
  logic [31:0] mw_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; string req; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  msi_capture_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mw_valid_i(mw_valid), .mw_addr_i(mw_addr),
    .mw_data_i(mw_data), .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: a read taken at the last posedge is compared here
  always @(posedge clk) rd_seen <= reg_re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) check(32'hDEAD, 32'h0, "R12 read without expectation");
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(reg_rdata, e.exp, e.req);
      end
    end
  end

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    exp_t e;
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    e.exp = exp; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    mw_valid = 1'b1; mw_addr = a; mw_data = d;
    @(negedge clk);
    mw_valid = 1'b0;
  endtask

  task automatic msi_and_wr(input logic [31:0] v, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    mw_valid = 1'b1; mw_addr = TGT; mw_data = v;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    mw_valid = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check({31'b0, irq}, 32'h0, "R1 irq after reset");
    check(reg_rdata, 32'h0, "R1 rdata after reset");
    rst_n = 1'b1;
    reg_rd(12'h820, 32'h0, "R1 target lo");
    reg_rd(12'h828, 32'h0, "R1 enable bank0");
    reg_rd(12'h830, 32'h0, "R1 status bank0");
    reg_rd(12'h884, 32'h0, "R1 status bank7");

    reg_wr(12'h820, TGT_LO);
    reg_wr(12'h824, 32'h1);
    reg_rd(12'h820, TGT_LO, "R2 target lo readback");
    reg_rd(12'h824, 32'h1, "R2 target hi readback");

    reg_wr(12'h828, 32'hFFFF_FFFF);
    reg_wr(12'h840, 32'h0000_0020);
    reg_wr(12'h87C, 32'h8000_0000);
    reg_rd(12'h840, 32'h20, "R3 bank2 enable offset");

    msi(TGT, 32'd3);                       // hi word is 1: miss
    reg_rd(12'h830, 32'h0, "R5 high word mismatch");
    reg_wr(12'h824, 32'h0);
    msi(TGT + 64'd4, 32'd3);
    reg_rd(12'h830, 32'h0, "R5 low word mismatch");

    msi(TGT, 32'd3);
    check({31'b0, irq}, 32'h1, "R10 irq after capture");
    reg_rd(12'h830, 32'h8, "R4 vector 3 captured");
    msi(TGT, 32'd69);
    reg_rd(12'h848, 32'h20, "R3 vector 69 in bank2 bit5");
    msi(TGT, 32'd70);
    reg_rd(12'h848, 32'h20, "R6 disabled vector 70 dropped");
    msi(TGT, 32'd255);
    reg_rd(12'h884, 32'h8000_0000, "R3 vector 255 in last bank");
    msi(TGT, 32'h104);
    msi(TGT, 32'h8000_0005);
    reg_rd(12'h830, 32'h8, "R7 out-of-range vectors ignored");

    reg_wr(12'h82C, 32'h8);
    reg_wr(12'h844, 32'h20);
    reg_wr(12'h880, 32'h8000_0000);
    check({31'b0, irq}, 32'h0, "R10 irq low when all masked");
    reg_rd(12'h830, 32'h8, "R10 mask does not hide status");
    reg_rd(12'h82C, 32'h8, "R3 bank0 mask offset");
    reg_wr(12'h82C, 32'h0);
    check({31'b0, irq}, 32'h1, "R10 irq after unmask");

    reg_wr(12'h830, 32'h0);
    reg_rd(12'h830, 32'h8, "R8 write zero keeps status");
    reg_wr(12'h830, 32'h10);
    reg_rd(12'h830, 32'h8, "R8 write cannot set status");
    reg_wr(12'h830, 32'h8);
    reg_rd(12'h830, 32'h0, "R8 write one clears");
    check({31'b0, irq}, 32'h0, "R10 irq low after clear");

    msi(TGT, 32'd7);
    msi_and_wr(32'd7, 12'h830, 32'h80);
    reg_rd(12'h830, 32'h80, "R9 capture wins same bit");
    msi_and_wr(32'd9, 12'h830, 32'h80);
    reg_rd(12'h830, 32'h200, "R9 capture and clear different bits");

    reg_rd(12'h900, 32'h0, "R11 undecoded 0x900");
    reg_wr(12'h890, 32'hFFFF_FFFF);
    reg_rd(12'h890, 32'h0, "R11 past last bank");
    reg_rd(12'h81C, 32'h0, "R11 below target");
    reg_rd(12'h832, 32'h0, "R11 misaligned");
    reg_rd(12'h830, 32'h200, "R11 write to hole had no effect");

    reg_wr(12'h828, 32'h0);
    msi(TGT, 32'd1);
    reg_rd(12'h830, 32'h200, "R6 vector dropped after disable");

    // R12: data changes only at the edge after the strobe
    reg_rd(12'h820, TGT_LO, "R12 new data after edge");
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 12'h824;
    check(reg_rdata, TGT_LO, "R12 holds previous data before edge");
    begin exp_t e; e.exp = 32'h0; e.req = "R12 second read"; sb_q.push_back(e); end
    @(negedge clk);
    reg_re = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule